// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Memory Guard with Error Capture

This block sits between a memory controller's request queues and a DRAM data path whose words are 32 data bits plus an 8-bit check byte, so each stored word is 40 bits wide. On the write side it turns a data word into its check byte. The data is first widened to 64 bits by padding the upper half with zeros, and a 64-bit SECDED code is then applied. On the read side it recomputes the code and forms an 8-bit syndrome. A single flipped bit is repaired before the word goes back to the requester, and two flipped bits are flagged as uncorrectable. The block never writes the repaired word back to memory, so scrubbing stays with software.

When reporting is enabled, every read that carries an error is recorded in a bank of capture slots, two by default. A slot holds the error kind, the syndrome and the read address. Only an empty slot accepts a new record. Slot 0 takes the first error, slot 1 takes the next one, and any later error is discarded until software clears a slot. Software reads a slot by selecting it, and empties it with a one-cycle clear strobe.

Top module: `secded_guard`

## Requirements
- R1: `wr_chk` depends only on `wr_data` and has no latency. The data is zero-extended to 64 bits. Data bit i takes the i-th code position, counting upward from 3, that is not a power of two (bit 0 at 3, bit 1 at 5, bit 31 at 38). For k = 0..6, check bit k is the XOR of the data bits whose position has bit k set. Check bit 7 is the XOR of all 64 data bits and check bits 0..6.
- R2: A read presented with `rd_valid` high in one cycle gives `rsp_valid` high in the next cycle only. A clean word comes back unchanged with both error flags low.
- R3: `rsp_syndrome[6:0]` is the recomputed check bits 0..6 XOR the received check bits 0..6. `rsp_syndrome[7]` is the XOR of all 40 received bits. A zero syndrome never raises a flag.
- R4: If the syndrome has odd parity and bits 6:0 match a data bit's position, that data bit is inverted in `rsp_data` and `rsp_corr` is high.
- R5: If the syndrome has odd parity and bits 6:0 are zero or a power of two (an error in a check bit), `rsp_data` equals the received data and `rsp_corr` is high.
- R6: A non-zero syndrome with even parity is uncorrectable. So is an odd-parity syndrome that points at no data or check position. In both cases `rsp_uncorr` is high, `rsp_corr` is low and `rsp_data` equals the received data.
- R7: When an error is reported, it fills the lowest-numbered empty slot. A full bank drops the error. A slot holds kind, syndrome and address unchanged until it is cleared. Kind codes are 00 empty, 01 correctable and 10 uncorrectable.
- R8: With `report_en` low in the read cycle, no slot changes because of that read. Correction and the response are unaffected.
- R9: `clr_en` empties slot `clr_sel` at the next edge. An error arriving in the same cycle treats that slot as already empty.
- R10: `log_kind`, `log_syn` and `log_addr` show slot `log_sel` combinationally.
- R11: After reset, `rsp_valid` is low and every slot reads kind 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_data | input | DATA_W | Word about to be written |
| wr_chk | output | 8 | Check byte stored alongside `wr_data` |
| rd_valid | input | 1 | A read word is present this cycle |
| rd_addr | input | ADDR_W | Address of the read word |
| rd_data | input | DATA_W | Data bits read from memory |
| rd_chk | input | 8 | Check bits read from memory |
| report_en | input | 1 | Allows errors to be captured |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | DATA_W | Corrected data |
| rsp_syndrome | output | 8 | Syndrome of the read |
| rsp_corr | output | 1 | Correctable error seen and handled |
| rsp_uncorr | output | 1 | Uncorrectable error seen |
| log_sel | input | SEL_W | Slot to view |
| clr_en | input | 1 | Clear strobe |
| clr_sel | input | SEL_W | Slot to clear |
| log_kind | output | 2 | Kind held in the viewed slot |
| log_syn | output | 8 | Syndrome held in the viewed slot |
| log_addr | output | ADDR_W | Address held in the viewed slot |

## Verification
The embedded properties watch several rules on every cycle. The response follows a read by exactly one cycle. A repair never changes more than one data bit. An uncorrectable response returns the data as it was read. An occupied slot stays frozen until it is cleared, a higher slot fills only behind an occupied lower one, and nothing is captured while reporting is off.

The bench scenarios cover what the properties cannot. They confirm the check byte and syndrome values against an independent model of the code and show that every single flip among the 40 bits is repaired. They also exercise a triple flip whose syndrome points past the last data position, and prove that a clear and an error landing in the same cycle put the error into the cleared slot.

// File: rtl/secded_pkg.sv
package secded_pkg;

  // Geometry of the SECDED code applied to the zero-extended word.
  localparam int unsigned EXT_W = 64;
  localparam int unsigned HAM_W = 7;
  localparam int unsigned CHK_W = HAM_W + 1;
  localparam int unsigned POS_LIMIT = 1 << HAM_W;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'b00,
    ERR_CORR   = 2'b01,
    ERR_UNCORR = 2'b10
  } err_kind_e;

  // Code position of extended data bit idx: the idx-th non power of two from 3.
  function automatic int unsigned data_pos(int unsigned idx);
    int unsigned seen;
    int unsigned found;
    seen  = 0;
    found = 0;
    for (int unsigned p = 3; p < POS_LIMIT; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (seen == idx) found = p;
        seen++;
      end
    end
    return found;
  endfunction

  // Data bits that feed Hamming check bit k.
  function automatic logic [EXT_W-1:0] ham_mask(int unsigned k);
    logic [EXT_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < EXT_W; i++) begin
      m[i] = ((data_pos(i) >> k) & 1) != 0;
    end
    return m;
  endfunction

endpackage

// File: rtl/secded_rst_sync.sv
module secded_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);

  logic [EXT_W-1:0] ext;
  logic [HAM_W-1:0] ham;

  always_comb begin
    ext = '0;
    ext[DATA_W-1:0] = data_i;
  end

  for (genvar k = 0; k < HAM_W; k++) begin : g_ham
    localparam logic [EXT_W-1:0] MASK = ham_mask(k);
    assign ham[k] = ^(ext & MASK);
  end

  assign chk_o = {^{ext, ham}, ham};

endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] rx_data,
  input  logic [CHK_W-1:0]  rx_chk,
  output logic [DATA_W-1:0] cor_data,
  output logic [CHK_W-1:0]  syndrome,
  output logic              err_corr,
  output logic              err_uncorr
);

  logic [CHK_W-1:0]  recalc;
  logic [HAM_W-1:0]  s_ham;
  logic              s_par;
  logic [DATA_W-1:0] data_hit;
  logic [HAM_W-1:0]  chk_hit;
  logic              located;

  secded_enc #(.DATA_W(DATA_W)) u_recalc (
    .data_i (rx_data),
    .chk_o  (recalc)
  );

  assign s_ham    = recalc[HAM_W-1:0] ^ rx_chk[HAM_W-1:0];
  assign s_par    = ^{rx_data, rx_chk};
  assign syndrome = {s_par, s_ham};

  for (genvar i = 0; i < DATA_W; i++) begin : g_dhit
    localparam logic [HAM_W-1:0] POS = HAM_W'(data_pos(i));
    assign data_hit[i] = (s_ham == POS);
  end

  for (genvar k = 0; k < HAM_W; k++) begin : g_chit
    localparam logic [HAM_W-1:0] CPOS = HAM_W'(1 << k);
    assign chk_hit[k] = (s_ham == CPOS);
  end

  always_comb begin
    located    = (s_ham == '0) | (|chk_hit) | (|data_hit);
    err_corr   = s_par & located;
    err_uncorr = (syndrome != '0) & ~err_corr;
    cor_data   = rx_data ^ (data_hit & {DATA_W{err_corr}});
  end

endmodule

// File: rtl/secded_log.sv
module secded_log
  import secded_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SLOTS  = 2,
  parameter int unsigned SEL_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic              ev_corr,
  input  logic              ev_uncorr,
  input  logic [CHK_W-1:0]  ev_syn,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              report_en,
  input  logic              clr_en,
  input  logic [SEL_W-1:0]  clr_sel,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [1:0]        rd_kind,
  output logic [CHK_W-1:0]  rd_syn,
  output logic [ADDR_W-1:0] rd_addr
);

  err_kind_e         kind_q [SLOTS];
  err_kind_e         kind_d [SLOTS];
  logic [CHK_W-1:0]  syn_q  [SLOTS];
  logic [CHK_W-1:0]  syn_d  [SLOTS];
  logic [ADDR_W-1:0] addr_q [SLOTS];
  logic [ADDR_W-1:0] addr_d [SLOTS];
  logic [SLOTS-1:0]  occ;
  logic [SLOTS-1:0]  clr_hit;
  logic [SLOTS-1:0]  free_eff;
  logic [SLOTS-1:0]  cap_hit;
  logic [SLOTS-1:0]  slot_we;
  logic              cap_req;
  logic              ev_err;

  // Next-state: clear first, then place a reported error in the first free slot.
  always_comb begin
    logic placed;
    ev_err  = ev_valid & (ev_corr | ev_uncorr);
    cap_req = ev_err & report_en;
    placed  = 1'b0;
    cap_hit = '0;
    for (int s = 0; s < SLOTS; s++) begin
      occ[s]      = (kind_q[s] != ERR_NONE);
      clr_hit[s]  = clr_en && (clr_sel == SEL_W'(s));
      free_eff[s] = !occ[s] || clr_hit[s];
      if (!placed && free_eff[s]) begin
        cap_hit[s] = cap_req;
        placed     = 1'b1;
      end
    end
    for (int s = 0; s < SLOTS; s++) begin
      kind_d[s] = kind_q[s];
      syn_d[s]  = syn_q[s];
      addr_d[s] = addr_q[s];
      if (clr_hit[s]) kind_d[s] = ERR_NONE;
      if (cap_hit[s]) begin
        kind_d[s] = ev_uncorr ? ERR_UNCORR : ERR_CORR;
        syn_d[s]  = ev_syn;
        addr_d[s] = ev_addr;
      end
      slot_we[s] = clr_hit[s] | cap_hit[s];
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        kind_q[s] <= ERR_NONE;
        syn_q[s]  <= '0;
        addr_q[s] <= '0;
      end else if (slot_we[s]) begin
        kind_q[s] <= kind_d[s];
        syn_q[s]  <= syn_d[s];
        addr_q[s] <= addr_d[s];
      end
    end

    // R7
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ[s] && !clr_hit[s]) |=> ($stable(kind_q[s]) && $stable(addr_q[s]) && $stable(syn_q[s])));

    // R8
    no_capture_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!report_en && !occ[s]) |=> !occ[s]);

    // R9
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit[s] && !ev_err) |=> !occ[s]);

    if (s > 0) begin : g_order
      // R7
      fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(occ[s]) |-> $past(occ[s-1]));
    end
  end

  always_comb begin
    rd_kind = ERR_NONE;
    rd_syn  = '0;
    rd_addr = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (rd_sel == SEL_W'(s)) begin
        rd_kind = kind_q[s];
        rd_syn  = syn_q[s];
        rd_addr = addr_q[s];
      end
    end
  end

endmodule

// File: rtl/secded_guard.sv
module secded_guard
  import secded_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned LOG_SLOTS = 2,
  localparam int unsigned SEL_W    = (LOG_SLOTS > 1) ? $clog2(LOG_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CHK_W-1:0]  wr_chk,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [CHK_W-1:0]  rd_chk,
  input  logic              report_en,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [CHK_W-1:0]  rsp_syndrome,
  output logic              rsp_corr,
  output logic              rsp_uncorr,
  input  logic [SEL_W-1:0]  log_sel,
  input  logic              clr_en,
  input  logic [SEL_W-1:0]  clr_sel,
  output logic [1:0]        log_kind,
  output logic [CHK_W-1:0]  log_syn,
  output logic [ADDR_W-1:0] log_addr
);

  logic              srst_n;
  logic [DATA_W-1:0] dec_data;
  logic [CHK_W-1:0]  dec_syn;
  logic              dec_corr;
  logic              dec_uncorr;

  logic              valid_q, valid_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [CHK_W-1:0]  syn_q, syn_d;
  logic              corr_q, corr_d;
  logic              unc_q, unc_d;

  secded_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  secded_enc #(.DATA_W(DATA_W)) u_wr_enc (
    .data_i (wr_data),
    .chk_o  (wr_chk)
  );

  secded_dec #(.DATA_W(DATA_W)) u_rd_dec (
    .rx_data    (rd_data),
    .rx_chk     (rd_chk),
    .cor_data   (dec_data),
    .syndrome   (dec_syn),
    .err_corr   (dec_corr),
    .err_uncorr (dec_uncorr)
  );

  secded_log #(
    .ADDR_W (ADDR_W),
    .SLOTS  (LOG_SLOTS),
    .SEL_W  (SEL_W)
  ) u_log (
    .clk       (clk),
    .rst_n     (srst_n),
    .ev_valid  (rd_valid),
    .ev_corr   (dec_corr),
    .ev_uncorr (dec_uncorr),
    .ev_syn    (dec_syn),
    .ev_addr   (rd_addr),
    .report_en (report_en),
    .clr_en    (clr_en),
    .clr_sel   (clr_sel),
    .rd_sel    (log_sel),
    .rd_kind   (log_kind),
    .rd_syn    (log_syn),
    .rd_addr   (log_addr)
  );

  always_comb begin
    valid_d = rd_valid;
    data_d  = rd_valid ? dec_data : data_q;
    syn_d   = rd_valid ? dec_syn : syn_q;
    corr_d  = rd_valid & dec_corr;
    unc_d   = rd_valid & dec_uncorr;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      syn_q   <= '0;
      corr_q  <= 1'b0;
      unc_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
      syn_q   <= syn_d;
      corr_q  <= corr_d;
      unc_q   <= unc_d;
    end
  end

  assign rsp_valid    = valid_q;
  assign rsp_data     = data_q;
  assign rsp_syndrome = syn_q;
  assign rsp_corr     = corr_q;
  assign rsp_uncorr   = unc_q;

  // R2
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!srst_n)
    rd_valid |=> rsp_valid);

  // R2
  rsp_single_cycle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !rd_valid |=> !rsp_valid);

  // R4
  repair_one_bit_chk: assert property (@(posedge clk) disable iff (!srst_n)
    rd_valid |-> ($countones(dec_data ^ rd_data) <= 1));

  // R6
  uncorr_passthru_chk: assert property (@(posedge clk) disable iff (!srst_n)
    rd_valid |=> (!rsp_uncorr || (rsp_data == $past(rd_data))));

  // R3
  zero_syn_quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (rsp_valid && rsp_syndrome == '0) |-> (!rsp_corr && !rsp_uncorr));

endmodule

// File: tb/secded_guard_bench.sv
`timescale 1ns/1ps
module secded_guard_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] wr_data;
  logic [7:0]  wr_chk;
  logic        rd_valid;
  logic [31:0] rd_addr;
  logic [31:0] rd_data;
  logic [7:0]  rd_chk;
  logic        report_en;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [7:0]  rsp_syndrome;
  logic        rsp_corr;
  logic        rsp_uncorr;
  logic        log_sel;
  logic        clr_en;
  logic        clr_sel;
  logic [1:0]  log_kind;
  logic [7:0]  log_syn;
  logic [31:0] log_addr;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  logic        done     = 1'b0;

  logic [1:0]  m_kind [2];
  logic [7:0]  m_syn  [2];
  logic [31:0] m_addr [2];

  always #4 clk = ~clk;

  secded_guard u_secded_guard (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_chk(wr_chk),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data), .rd_chk(rd_chk),
    .report_en(report_en), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_syndrome(rsp_syndrome), .rsp_corr(rsp_corr), .rsp_uncorr(rsp_uncorr),
    .log_sel(log_sel), .clr_en(clr_en), .clr_sel(clr_sel),
    .log_kind(log_kind), .log_syn(log_syn), .log_addr(log_addr)
  );

  function automatic int unsigned pos_of(int unsigned idx);
    int unsigned n = 0;
    int unsigned r = 0;
    for (int unsigned p = 3; p < 128; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == idx) r = p;
        n++;
      end
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_chk(logic [31:0] d);
    logic [6:0] h = '0;
    for (int i = 0; i < 32; i++) begin
      if (d[i]) h = h ^ 7'(pos_of(i));
    end
    return {^{d, h}, h};
  endfunction

  function automatic logic [7:0] ref_syn(logic [31:0] d, logic [7:0] c);
    logic [7:0] e;
    e = ref_chk(d);
    return {^{d, c}, e[6:0] ^ c[6:0]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_logs(input string tag);
    for (int s = 0; s < 2; s++) begin
      @(negedge clk);
      log_sel = s[0];
      #1;
      chk({tag, " R10 kind"}, 64'(log_kind), 64'(m_kind[s]));
      if (m_kind[s] != 2'b00) begin
        chk({tag, " R10 syn"},  64'(log_syn),  64'(m_syn[s]));
        chk({tag, " R10 addr"}, 64'(log_addr), 64'(m_addr[s]));
      end
    end
  endtask

  task automatic do_read(input logic [31:0] a, input logic [31:0] d, input logic [7:0] c,
                         input logic [31:0] exp_d, input logic exp_corr, input logic exp_unc,
                         input logic en, input logic do_clr, input logic cs, input string tag);
    logic [7:0] es;
    es = ref_syn(d, c);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a; rd_data = d; rd_chk = c;
    report_en = en; clr_en = do_clr; clr_sel = cs;
    @(negedge clk);
    rd_valid = 1'b0; clr_en = 1'b0; report_en = 1'b1;
    chk({tag, " R2 valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " data"}, 64'(rsp_data), 64'(exp_d));
    chk({tag, " corr"}, 64'(rsp_corr), 64'(exp_corr));
    chk({tag, " uncorr"}, 64'(rsp_uncorr), 64'(exp_unc));
    chk({tag, " R3 syndrome"}, 64'(rsp_syndrome), 64'(es));
    if (do_clr) m_kind[cs] = 2'b00;
    if (en && (exp_corr || exp_unc)) begin
      for (int s = 0; s < 2; s++) begin
        if (m_kind[s] == 2'b00) begin
          m_kind[s] = exp_unc ? 2'b10 : 2'b01;
          m_syn[s]  = es;
          m_addr[s] = a;
          break;
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  c;
    void'($urandom(32'h5EED));
    for (int s = 0; s < 2; s++) begin
      m_kind[s] = 2'b00; m_syn[s] = '0; m_addr[s] = '0;
    end
    rst_n = 1'b0; wr_data = '0; rd_valid = 1'b0; rd_addr = '0; rd_data = '0; rd_chk = '0;
    report_en = 1'b1; log_sel = 1'b0; clr_en = 1'b0; clr_sel = 1'b0;
    repeat (3) @(negedge clk);
    // R11 during reset
    chk("R11 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check_logs("R11");

    // R1 directed write codes
    @(negedge clk); wr_data = 32'h0; #1;
    chk("R1 zero word", 64'(wr_chk), 64'(ref_chk(32'h0)));
    @(negedge clk); wr_data = 32'hFFFF_FFFF; #1;
    chk("R1 ones word", 64'(wr_chk), 64'(ref_chk(32'hFFFF_FFFF)));

    // R2 clean read, then response drops
    d = 32'hCAFE_1234; c = ref_chk(d);
    do_read(32'h100, d, c, d, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R2 clean");
    @(negedge clk);
    chk("R2 valid drops", 64'(rsp_valid), 64'd0);

    // R4 data bit 0 and bit 31 flipped
    d = 32'h1357_9BDF; c = ref_chk(d);
    do_read(32'h200, d ^ 32'h1, c, d, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R4 bit0");
    do_read(32'h204, d ^ 32'h8000_0000, c, d, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R4 bit31");
    check_logs("R7 first two");

    // R7 bank full: dropped
    do_read(32'h208, d, c ^ 8'h80, d, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R5 chk7 full");
    check_logs("R7 drop");

    // R9 clear slot 0 in the same cycle as an error: lands in slot 0
    do_read(32'h20C, d, c ^ 8'h01, d, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R5 chk0 clr");
    check_logs("R9 same cycle");

    // R9 plain clears
    @(negedge clk); clr_en = 1'b1; clr_sel = 1'b0;
    @(negedge clk); clr_sel = 1'b1;
    @(negedge clk); clr_en = 1'b0;
    m_kind[0] = 2'b00; m_kind[1] = 2'b00;
    check_logs("R9 cleared");

    // R8 reporting off
    do_read(32'h300, d ^ 32'h0000_0300, c, d ^ 32'h0000_0300, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6 R8 off");
    check_logs("R8 nothing kept");

    // R6 triple flip on bits 29..31: syndrome points past data
    do_read(32'h304, d ^ 32'hE000_0000, c, d ^ 32'hE000_0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R6 triple");
    check_logs("R6 R7 logged");

    // Random mix
    for (int it = 0; it < 400; it++) begin
      logic [39:0] w;
      int unsigned nf, p1, p2;
      string tag;
      logic en, dc, cs;
      d = $urandom;
      @(negedge clk); wr_data = d; #1;
      chk("R1 random", 64'(wr_chk), 64'(ref_chk(d)));
      w  = {ref_chk(d), d};
      nf = $urandom % 3;
      p1 = $urandom % 40;
      p2 = (p1 + 1 + ($urandom % 39)) % 40;
      if (nf >= 1) w[p1] = ~w[p1];
      if (nf == 2) w[p2] = ~w[p2];
      tag = (nf == 0) ? "R2 rnd" : (nf == 2) ? "R6 rnd" : (p1 < 32) ? "R4 rnd" : "R5 rnd";
      en = ($urandom % 8) != 0;
      dc = ($urandom % 8) == 0;
      cs = 1'($urandom % 2);
      do_read($urandom, w[31:0], w[39:32], (nf == 2) ? w[31:0] : d,
              nf == 1, nf == 2, en, dc, cs, tag);
      if (it % 16 == 15) check_logs("R7 rnd");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule